// File: doc/BRIEF.md
# Bidirectional Port Controller with Input Pull-ups

This block controls an eight-bit general-purpose I/O port. Each pin can drive a value, float, or float with a weak pull-up turned on. Two storage registers set the pin mode: a mode register that chooses input or output, and a level register. In output mode the level register gives the driven value. In input mode it turns the pull-up on. A third bus location holds no storage. Reading it returns the levels actually present on the pads, after they pass through a synchronizer.

The block also serves two neighbouring functions. A timer compare output can take over pin 3 while that pin is an output and the timer asserts its enable. Pins 0 and 1 raise flags whenever they are usable as comparator inputs (positive and negative). A low level on the reset input puts every pad into high impedance with its pull-up off, and it does so at once, with or without a running clock.

Top module: `pio_port_ctl`

## Requirements
- R1: For every pin n, `pad_oe[n]` equals the stored mode bit n (1 = output, 0 = input). All eight pins behave the same way.
- R2: `pad_pu[n]` is 1 only when mode bit n is 0 and level bit n is 1. It is 0 whenever the pin is an output.
- R3: For an output pin, `pad_out[n]` equals level bit n. For an input pin, `pad_out[n]` is 0.
- R4: Address 1 reads back the mode register, address 2 reads back the level register, and address 3 reads as 0x00. A write to address 0 or address 3 changes neither register.
- R5: While `rst_n` is low, `pad_oe` and `pad_pu` are all zero. This holds at once with no clock edge, and both registers are cleared.
- R6: A read at address 0 returns the pad levels `pad_in` as they were two rising clock edges earlier.
- R7: When mode bit 3 is 1 and `tmr_cmp_en` is 1, `pad_out[3]` follows `tmr_cmp_val`. In any other case, pin 3 behaves exactly as R3 states.
- R8: `cmp_pos_ok` is 1 exactly when pin 0 is an input with its pull-up off (mode bit 0 = 0, level bit 0 = 0). `cmp_neg_ok` is the same for pin 1.
- R9: A write with `wr_en` high is captured on the next rising edge, and the pad controls show the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 pin levels, 1 mode, 2 level |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pad_in | input | 8 | Logic levels sensed on the pads |
| pad_oe | output | 8 | Per-pin output-driver enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| tmr_cmp_val | input | 1 | Timer compare output level |
| tmr_cmp_en | input | 1 | Timer compare output enable |
| cmp_pos_ok | output | 1 | Pin 0 usable as comparator positive input |
| cmp_neg_ok | output | 1 | Pin 1 usable as comparator negative input |

## Verification
The hardest condition to reach is a reset that arrives while pins are driving and no clock is running. The registers must then clear through their asynchronous path and not on any edge. The bench sets up active outputs and pull-ups, stops its clock generator at a low phase, and pulls reset low. It then samples the pad controls after a short delay with no edge in between. The two-cycle pin-sense latency is checked against a delay-line model in the bench that advances on every step, including steps that write registers.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W      = 8;
  localparam int unsigned PIO_ADDR_W = 2;

  typedef enum logic [PIO_ADDR_W-1:0] {
    SEL_PINS  = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_NONE  = 2'd3
  } pio_sel_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pio_pad_ctl_t;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned CW = $clog2(STAGES + 1);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

  // warm-up counter so the stage checks only look at cycles after reset
  logic [CW-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                       warm_q <= '0;
    else if (warm_q != CW'(STAGES))    warm_q <= warm_q + 1'b1;
  end

  a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_ni)
    (warm_q != '0) |-> (stg_q[0] == $past(din)));

  for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
    a_r6_stage_shift: assert property (@(posedge clk) disable iff (!rst_ni)
      (warm_q > CW'(g)) |-> (stg_q[g] == $past(stg_q[g-1])));
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = PIO_W
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [PIO_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic [W-1:0]          wr_data,
  input  logic [W-1:0]          pins_sync,
  output logic [W-1:0]          mode_q,
  output logic [W-1:0]          level_q,
  output logic [W-1:0]          rd_data
);
  pio_sel_e   sel;
  logic       mode_we;
  logic       level_we;
  logic [W-1:0] mode_d;
  logic [W-1:0] level_d;

  assign sel = pio_sel_e'(addr);

  always_comb begin
    mode_we  = wr_en && (sel == SEL_MODE);
    level_we = wr_en && (sel == SEL_LEVEL);
    mode_d   = wr_data;
    level_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       level_q <= '0;
    else if (level_we) level_q <= level_d;
  end

  always_comb begin
    unique case (sel)
      SEL_PINS:  rd_data = pins_sync;
      SEL_MODE:  rd_data = mode_q;
      SEL_LEVEL: rd_data = level_q;
      default:   rd_data = '0;
    endcase
  end

  a_r4_pin_addr_no_store: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (addr == 2'd0 || addr == 2'd3)) |=>
      ($stable(mode_q) && $stable(level_q)));

  a_r9_mode_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == 2'd1) |=> (mode_q == $past(wr_data)));
endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
  import pio_pkg::*;
#(
  parameter bit HAS_TMR = 1'b0
) (
  input  logic         mode,
  input  logic         level,
  input  logic         tmr_val,
  input  logic         tmr_en,
  output pio_pad_ctl_t ctl,
  output logic         analog_ok
);
  logic drive_val;

  if (HAS_TMR) begin : g_tmr
    assign drive_val = tmr_en ? tmr_val : level;
  end else begin : g_plain
    logic unused_tmr;
    assign unused_tmr = tmr_val ^ tmr_en;
    assign drive_val  = level;
  end

  always_comb begin
    ctl.oe    = mode;
    ctl.out   = mode & drive_val;
    ctl.pu    = ~mode & level;
    analog_ok = ~mode & ~level;
  end
endmodule

// File: rtl/pio_port_ctl.sv
module pio_port_ctl
  import pio_pkg::*;
#(
  parameter int unsigned W           = PIO_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned TMR_BIT     = 3,
  parameter int unsigned CMP_POS_BIT = 0,
  parameter int unsigned CMP_NEG_BIT = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIO_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic [W-1:0]          wr_data,
  output logic [W-1:0]          rd_data,
  input  logic [W-1:0]          pad_in,
  output logic [W-1:0]          pad_oe,
  output logic [W-1:0]          pad_out,
  output logic [W-1:0]          pad_pu,
  input  logic                  tmr_cmp_val,
  input  logic                  tmr_cmp_en,
  output logic                  cmp_pos_ok,
  output logic                  cmp_neg_ok
);
  logic         rst_ni;
  logic [W-1:0] pins_sync;
  logic [W-1:0] mode_q;
  logic [W-1:0] level_q;
  logic [W-1:0] analog_ok;

  pio_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  pio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_ni (rst_ni),
    .din    (pad_in),
    .dout   (pins_sync)
  );

  pio_regs #(.W(W)) regs_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pins_sync (pins_sync),
    .mode_q    (mode_q),
    .level_q   (level_q),
    .rd_data   (rd_data)
  );

  for (genvar n = 0; n < W; n++) begin : g_pin
    pio_pad_ctl_t ctl;
    pio_pin_cell #(.HAS_TMR(n == TMR_BIT)) cell_i (
      .mode      (mode_q[n]),
      .level     (level_q[n]),
      .tmr_val   (tmr_cmp_val),
      .tmr_en    (tmr_cmp_en),
      .ctl       (ctl),
      .analog_ok (analog_ok[n])
    );
    assign pad_oe[n]  = ctl.oe;
    assign pad_out[n] = ctl.out;
    assign pad_pu[n]  = ctl.pu;
  end

  assign cmp_pos_ok = analog_ok[CMP_POS_BIT];
  assign cmp_neg_ok = analog_ok[CMP_NEG_BIT];

  a_r7_timer_drives_pin: assert property (@(posedge clk) disable iff (!rst_ni)
    (tmr_cmp_en && pad_oe[TMR_BIT]) |-> (pad_out[TMR_BIT] == tmr_cmp_val));

  a_r8_pos_flag_idle_pin: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_pos_ok |-> (!pad_oe[CMP_POS_BIT] && !pad_pu[CMP_POS_BIT]));

  a_r8_neg_flag_idle_pin: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_neg_ok |-> (!pad_oe[CMP_NEG_BIT] && !pad_pu[CMP_NEG_BIT]));

  a_r9_write_to_pads: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == 2'd1) |=> (pad_oe == $past(wr_data)));
endmodule

// File: tb/pio_port_ctl_tb_top.sv
module pio_port_ctl_tb_top;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] pad_in;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic       tmr_cmp_val, tmr_cmp_en;
  logic       cmp_pos_ok, cmp_neg_ok;

  int total = 0;
  int bad   = 0;

  always #5 if (clk_run) clk = ~clk;

  pio_port_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .tmr_cmp_val(tmr_cmp_val), .tmr_cmp_en(tmr_cmp_en),
    .cmp_pos_ok(cmp_pos_ok), .cmp_neg_ok(cmp_neg_ok)
  );

  typedef struct {
    string      req;
    logic [7:0] oe, out, pu, rd;
    logic       cp, cn;
  } exp_t;

  exp_t sb_q[$];

  // reference state built from the requirements
  logic [7:0] m_mode, m_lvl, m_s1, m_s2;

  function automatic exp_t predict(string req, logic [1:0] a, logic ten, logic tval);
    exp_t e;
    e.req = req;
    e.oe  = m_mode;
    e.pu  = ~m_mode & m_lvl;
    e.out = m_mode & m_lvl;
    if (m_mode[3] && ten) e.out[3] = tval;
    case (a)
      2'd0: e.rd = m_s2;
      2'd1: e.rd = m_mode;
      2'd2: e.rd = m_lvl;
      default: e.rd = 8'h00;
    endcase
    e.cp = ~m_mode[0] & ~m_lvl[0];
    e.cn = ~m_mode[1] & ~m_lvl[1];
    return e;
  endfunction

  task automatic step(string req, logic [1:0] a, logic we, logic [7:0] wd,
                      logic [7:0] pins, logic ten, logic tval);
    @(negedge clk);
    addr = a; wr_en = we; wr_data = wd; pad_in = pins;
    tmr_cmp_en = ten; tmr_cmp_val = tval;
    if (we && a == 2'd1) m_mode = wd;
    if (we && a == 2'd2) m_lvl  = wd;
    m_s2 = m_s1;
    m_s1 = pins;
    sb_q.push_back(predict(req, a, ten, tval));
  endtask

  // monitor: sample 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (pad_oe !== e.oe || pad_out !== e.out || pad_pu !== e.pu ||
          rd_data !== e.rd || cmp_pos_ok !== e.cp || cmp_neg_ok !== e.cn) begin
        bad++;
        $display("FAIL %s: act oe=%h out=%h pu=%h rd=%h cp=%b cn=%b exp oe=%h out=%h pu=%h rd=%h cp=%b cn=%b",
                 e.req, pad_oe, pad_out, pad_pu, rd_data, cmp_pos_ok, cmp_neg_ok,
                 e.oe, e.out, e.pu, e.rd, e.cp, e.cn);
      end
    end
  end

  task automatic direct(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reset_seq();
    rst_n = 1'b0; addr = 2'd1; wr_en = 1'b0; wr_data = 8'h00; pad_in = 8'h00;
    tmr_cmp_en = 1'b0; tmr_cmp_val = 1'b0;
    m_mode = '0; m_lvl = '0; m_s1 = '0; m_s2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    reset_seq();
    // R5 reset state of the pads and the mode register
    direct("R5 oe after reset", pad_oe, 8'h00);
    direct("R5 pu after reset", pad_pu, 8'h00);
    direct("R5 mode readback after reset", rd_data, 8'h00);

    // R9 R1 R2 R3: all four mode/level combinations across the byte
    step("R9 mode write",      2'd1, 1'b1, 8'hF0, 8'h00, 1'b0, 1'b0);
    step("R1 R2 R3 combos",    2'd2, 1'b1, 8'hA5, 8'h00, 1'b0, 1'b0);
    step("R4 mode readback",   2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R4 level readback",  2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R4 addr3 reads zero",2'd3, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    // R4 ignored writes
    step("R4 write to pin addr",  2'd0, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0);
    step("R4 write to addr3",     2'd3, 1'b1, 8'h0F, 8'h00, 1'b0, 1'b0);
    step("R4 mode unchanged",     2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R4 level unchanged",    2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);

    // R6 pin sense latency with a changing pattern
    step("R6 pins t0", 2'd0, 1'b0, 8'h00, 8'h3C, 1'b0, 1'b0);
    step("R6 pins t1", 2'd0, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0);
    step("R6 pins t2", 2'd0, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b0);
    step("R6 pins t3", 2'd0, 1'b1, 8'h77, 8'h5A, 1'b0, 1'b0);
    step("R6 pins t4", 2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);

    // R7 timer override on pin 3
    step("R7 mode pin3 out", 2'd1, 1'b1, 8'h08, 8'h00, 1'b1, 1'b1);
    step("R7 timer high",    2'd2, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1);
    step("R7 timer low",     2'd2, 1'b1, 8'h08, 8'h00, 1'b1, 1'b0);
    step("R7 enable off",    2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R7 pin3 input",    2'd1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1);

    // R8 comparator qualification
    step("R8 both idle",     2'd2, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R8 pos pullup",    2'd2, 1'b1, 8'h01, 8'h00, 1'b0, 1'b0);
    step("R8 neg pullup",    2'd2, 1'b1, 8'h02, 8'h00, 1'b0, 1'b0);
    step("R8 level clear",   2'd2, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R8 neg driven",    2'd1, 1'b1, 8'h02, 8'h00, 1'b0, 1'b0);
    step("R8 pos driven",    2'd1, 1'b1, 8'h01, 8'h00, 1'b0, 1'b0);

    // R1 every pin alike: walking one in mode and level
    for (int i = 0; i < 8; i++) begin
      step("R1 walk mode",  2'd1, 1'b1, 8'(1 << i), 8'h00, 1'b0, 1'b0);
      step("R2 walk level", 2'd2, 1'b1, ~8'(1 << i), 8'h00, 1'b0, 1'b0);
    end

    // R5 asynchronous reset with the clock stopped
    step("R5 setup mode",  2'd1, 1'b1, 8'h0F, 8'h00, 1'b0, 1'b0);
    step("R5 setup level", 2'd2, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0);
    drain();
    clk_run = 1'b0;
    #20;
    rst_n = 1'b0;
    #1;
    direct("R5 oe no clock", pad_oe, 8'h00);
    direct("R5 pu no clock", pad_pu, 8'h00);
    clk_run = 1'b1;
    #20;
    reset_seq();
    direct("R5 mode cleared", rd_data, 8'h00);
    addr = 2'd2;
    #1;
    direct("R5 level cleared", rd_data, 8'h00);
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule